// File: doc/BRIEF.md
# T1/E1 Transmit Line Coder

This block turns one channel of transmit-side system data into ternary line symbols for a T1/J1 or E1 line driver. Each symbol is a positive pulse, a negative pulse or a space. Input bits are captured on a chosen edge of the transmit clock, and can be inverted first. In single-rail operation one data line carries binary data. That data is coded as alternate mark inversion, or with zero substitution: eight-zero substitution on T1/J1 and four-zero substitution on E1. In dual-rail operation the coder is bypassed, and a pair of rails selects the pulse polarity directly.

Every symbol travels through a fixed eight-slot delay line. This gives the substitution logic room to rewrite a run of zeros before any of it reaches the line, and it makes the latency the same in every mode.

A separate monitor, clocked by a free-running master clock, watches the transmit clock. If the transmit clock stops, the monitor sets a sticky loss flag and raises an interrupt that can be masked.

Top module: `tx_line_coder`

## Requirements
- R1: While reset is asserted and directly after it, both line rails are low, the loss status is 0 and the interrupt is 0.
- R2: When `cfg_dual`=1 the coder is bypassed in both T1 and E1 modes, whatever `cfg_subst` is set to.
  - `sys_rail_a`=1 with `sys_rail_b`=0 gives a negative pulse.
  - `sys_rail_a`=0 with `sys_rail_b`=1 gives a positive pulse.
  - Equal rails give a space, and long runs of spaces are never substituted.
- R3: When `cfg_dual`=0 and `cfg_subst`=0, the data on `sys_rail_a` is coded as alternate mark inversion in both T1 (`cfg_t1`=1) and E1 (`cfg_t1`=0). A 0 gives a space. Each 1 gives a pulse of the opposite polarity to the previous pulse, and the first pulse after reset is positive.
- R4: When `cfg_t1`=1, `cfg_subst`=1 and `cfg_dual`=0, each run of eight zeros, counted from the last 1 or the last substitution, is sent as 0,0,0,V,B,0,V,B.
  - The first V has the same polarity as the pulse before it, and each B is opposite to the pulse before it.
  - A run of seven zeros is sent unchanged.
- R5: When `cfg_t1`=0, `cfg_subst`=1 and `cfg_dual`=0, each run of four zeros is replaced so that successive violations alternate in polarity.
  - If an odd number of pulses has been sent since the last violation, the run becomes 0,0,0,V.
  - Otherwise it becomes B,0,0,V. The count starts even at reset.
- R6: A positive pulse is `line_pos`=1 with `line_neg`=0, a negative pulse is `line_neg`=1 with `line_pos`=0, and a space is both rails low. A bit held between rising edges k and k+1 appears on the line rails after rising edge k+10 when sampled on the rising edge.
- R7: When `cfg_invert`=1, both input rails are complemented before sampling and coding.
- R8: When `cfg_fall_edge`=1, input data is sampled on the falling edge of `tclk`, and the symbol appears one cycle earlier, after rising edge k+9.
- R9: `loss_status` is set once `tclk` has shown no edge for more than `LOSS_LIMIT` (70) `mclk` cycles. It is never set while `tclk` toggles.
- R10: `loss_status` stays set until a one-cycle pulse on `loss_clr`. After that it stays clear while `tclk` keeps toggling.
- R11: `loss_irq` equals `loss_status` while `loss_mask`=0, and is 0 while `loss_mask`=1.
- R12: `line_pos` and `line_neg` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tclk | input | 1 | Transmit clock; the coder runs on its rising edge |
| mclk | input | 1 | Free-running master clock for the loss monitor |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cfg_t1 | input | 1 | 1 = T1/J1 (eight-zero substitution), 0 = E1 (four-zero substitution) |
| cfg_dual | input | 1 | 1 = dual-rail input with coder bypass, 0 = single-rail |
| cfg_subst | input | 1 | 1 = zero substitution enabled, 0 = plain alternate mark inversion |
| cfg_fall_edge | input | 1 | 1 = sample inputs on the falling edge of tclk |
| cfg_invert | input | 1 | 1 = complement both input rails |
| sys_rail_a | input | 1 | Single-rail data, or the first rail in dual-rail mode |
| sys_rail_b | input | 1 | Second rail in dual-rail mode |
| loss_mask | input | 1 | 1 = suppress the clock-loss interrupt |
| loss_clr | input | 1 | Write-one-to-clear pulse for the loss status (mclk domain) |
| line_pos | output | 1 | Positive pulse rail |
| line_neg | output | 1 | Negative pulse rail |
| loss_status | output | 1 | Sticky transmit-clock-loss flag |
| loss_irq | output | 1 | Clock-loss interrupt |

## Verification
The bench drives zero runs of exactly seven, eight, nine and sixteen bits. A coder with the wrong run count would substitute too early, or would leave a long run with no pulses. On E1 it places four-zero runs after odd and even pulse counts and runs them back to back. Choosing the wrong fill pattern shows up as two same-polarity violations, or as a misplaced balancing pulse. Dual-rail streams with long stretches of equal rails catch a bypass that still substitutes, and they also catch a swapped rail-to-polarity mapping. The clock-loss test probes both sides of the 70-cycle threshold and then clears the flag. This exposes a monitor that trips while the clock is running, one that never latches, or one that ignores masking or clearing.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  // zero-run lengths that trigger substitution
  localparam int B8_RUN = 8;
  localparam int HD_RUN = 4;
  localparam int ZC_W   = $clog2(B8_RUN + 1);

  // what a delay-line slot holds; polarity is resolved at the output
  typedef enum logic [2:0] {
    K_SPACE = 3'd0,
    K_MARK  = 3'd1,   // ordinary one: alternates polarity
    K_VIOL  = 3'd2,   // violation: repeats the last polarity
    K_BAL   = 3'd3,   // balancing pulse: alternates polarity
    K_FPOS  = 3'd4,   // forced positive (dual rail)
    K_FNEG  = 3'd5    // forced negative (dual rail)
  } sym_kind_e;

  // dual-rail mapping: first rail alone -> negative, second alone -> positive
  function automatic sym_kind_e rail_pair_kind(input logic ra, input logic rb);
    if (ra && !rb) return K_FNEG;
    if (!ra && rb) return K_FPOS;
    return K_SPACE;
  endfunction

  function automatic logic kind_is_pulse(input sym_kind_e k);
    return k != K_SPACE;
  endfunction

  // polarity of the emitted pulse: 1 = positive
  function automatic logic kind_positive(input sym_kind_e k, input logic last_pos);
    case (k)
      K_MARK, K_BAL: return !last_pos;
      K_VIOL:        return last_pos;
      K_FPOS:        return 1'b1;
      default:       return 1'b0;
    endcase
  endfunction

  // kinds that move the alternation tracker
  function automatic logic kind_tracks(input sym_kind_e k);
    return (k == K_MARK) || (k == K_BAL) || (k == K_VIOL);
  endfunction

  // true when the incoming zero completes a run of run_len
  function automatic logic run_complete(input logic [ZC_W-1:0] zeros_seen, input int run_len);
    return zeros_seen == ZC_W'(run_len - 1);
  endfunction

endpackage

// File: rtl/tlc_sampler.sv
module tlc_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_sel,
  input  logic invert,
  input  logic rail_a,
  input  logic rail_b,
  output logic smp_a,
  output logic smp_b
);

  logic [1:0] pol_in;
  logic [1:0] rise_q;
  logic [1:0] fall_q;

  assign pol_in = {rail_a, rail_b} ^ {2{invert}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= 2'b00;
    else        rise_q <= pol_in;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 2'b00;
    else        fall_q <= pol_in;
  end

  assign {smp_a, smp_b} = fall_sel ? fall_q : rise_q;

endmodule

// File: rtl/tlc_coder.sv
module tlc_coder
  import tlc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_t1,
  input  logic cfg_dual,
  input  logic cfg_subst,
  input  logic smp_a,
  input  logic smp_b,
  output logic line_pos,
  output logic line_neg
);

  localparam int PIPE_DEPTH = B8_RUN;
  localparam logic [ZC_W-1:0] ZC_MAX = '1;

  sym_kind_e       pipe_q [PIPE_DEPTH];
  sym_kind_e       pipe_d [PIPE_DEPTH];
  sym_kind_e       new_kind;
  sym_kind_e       head;
  logic [ZC_W-1:0] zc_q, zc_d;
  logic            par_q, par_d;
  logic            last_q;
  logic            coding_on, b8_hit, hd_hit;
  logic            head_pulse, head_pos;
  logic            viol_emit;

  // ---------------- input stage and substitution ----------------
  always_comb begin
    new_kind  = cfg_dual ? rail_pair_kind(smp_a, smp_b) : (smp_a ? K_MARK : K_SPACE);
    coding_on = !cfg_dual && cfg_subst;
    b8_hit    = coding_on &&  cfg_t1 && !smp_a && run_complete(zc_q, B8_RUN);
    hd_hit    = coding_on && !cfg_t1 && !smp_a && run_complete(zc_q, HD_RUN);

    pipe_d[0] = new_kind;
    for (int i = 1; i < PIPE_DEPTH; i++) pipe_d[i] = pipe_q[i-1];

    // slot 0 is the newest entry; the run's oldest zero now sits at B8_RUN-1
    if (b8_hit) begin
      pipe_d[B8_RUN-4] = K_VIOL;
      pipe_d[B8_RUN-5] = K_BAL;
      pipe_d[1]        = K_VIOL;
      pipe_d[0]        = K_BAL;
    end
    if (hd_hit) begin
      pipe_d[0] = K_VIOL;
      if (!par_q) pipe_d[HD_RUN-1] = K_BAL;
    end

    if (!coding_on || smp_a || b8_hit || hd_hit) zc_d = '0;
    else if (zc_q != ZC_MAX)                     zc_d = zc_q + 1'b1;
    else                                         zc_d = zc_q;

    if (hd_hit)                 par_d = 1'b0;
    else if (!cfg_dual && smp_a) par_d = !par_q;
    else                        par_d = par_q;
  end

  for (genvar s = 0; s < PIPE_DEPTH; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[s] <= K_SPACE;
      else        pipe_q[s] <= pipe_d[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zc_q  <= '0;
      par_q <= 1'b0;
    end else begin
      zc_q  <= zc_d;
      par_q <= par_d;
    end
  end

  // ---------------- output stage ----------------
  assign head       = pipe_q[PIPE_DEPTH-1];
  assign head_pulse = kind_is_pulse(head);
  assign head_pos   = kind_positive(head, last_q);
  assign viol_emit  = (head == K_VIOL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q   <= 1'b0;     // so the first mark goes out positive
      line_pos <= 1'b0;
      line_neg <= 1'b0;
    end else begin
      line_pos <= head_pulse &&  head_pos;
      line_neg <= head_pulse && !head_pos;
      if (kind_tracks(head)) last_q <= head_pos;
    end
  end

  // ---------------- assertions ----------------
  logic ami_mode, hdb3_mode;
  logic out_seen_q, out_prev_pos_q;
  logic v_seen_q, v_prev_pos_q;

  assign ami_mode  = !cfg_dual && !cfg_subst;
  assign hdb3_mode = !cfg_dual && cfg_subst && !cfg_t1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_seen_q     <= 1'b0;
      out_prev_pos_q <= 1'b0;
      v_seen_q       <= 1'b0;
      v_prev_pos_q   <= 1'b0;
    end else begin
      if (line_pos || line_neg) begin
        out_seen_q     <= 1'b1;
        out_prev_pos_q <= line_pos;
      end
      if (viol_emit) begin
        v_seen_q     <= 1'b1;
        v_prev_pos_q <= head_pos;
      end
    end
  end

  a_r12_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_pos && line_neg));

  a_r3_ami_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (ami_mode && out_seen_q && (line_pos || line_neg)) |-> (line_pos != out_prev_pos_q));

  a_r5_viol_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (hdb3_mode && viol_emit && v_seen_q) |-> (head_pos != v_prev_pos_q));

endmodule

// File: rtl/tlc_clk_monitor.sv
module tlc_clk_monitor #(
  parameter int LOSS_LIMIT = 70
) (
  input  logic mclk,
  input  logic rst_n,
  input  logic tclk,
  input  logic mask,
  input  logic clr,
  output logic status,
  output logic irq
);

  localparam int CNT_W = $clog2(LOSS_LIMIT + 2);
  localparam logic [CNT_W-1:0] CNT_TRIP = CNT_W'(LOSS_LIMIT);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(LOSS_LIMIT + 1);

  logic [2:0]       sync_q;     // [1:0] synchronizer, [2] edge history
  logic             tclk_edge;
  logic [CNT_W-1:0] idle_cnt_q;
  logic             trip_evt;

  assign tclk_edge = sync_q[2] ^ sync_q[1];
  assign trip_evt  = !tclk_edge && (idle_cnt_q == CNT_TRIP);

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= 3'b000;
      idle_cnt_q <= '0;
      status     <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], tclk};
      if (tclk_edge)                 idle_cnt_q <= '0;
      else if (idle_cnt_q != CNT_SAT) idle_cnt_q <= idle_cnt_q + 1'b1;
      if (trip_evt) status <= 1'b1;
      else if (clr) status <= 1'b0;
    end
  end

  assign irq = status && !mask;

  a_r10_sticky_hold: assert property (@(posedge mclk) disable iff (!rst_n)
    (status && !clr) |=> status);

  a_r9_trip_at_limit: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(status) |-> ($past(idle_cnt_q) == CNT_TRIP));

endmodule

// File: rtl/tx_line_coder.sv
module tx_line_coder #(
  parameter int LOSS_LIMIT = 70
) (
  input  logic tclk,
  input  logic mclk,
  input  logic rst_n,
  input  logic cfg_t1,
  input  logic cfg_dual,
  input  logic cfg_subst,
  input  logic cfg_fall_edge,
  input  logic cfg_invert,
  input  logic sys_rail_a,
  input  logic sys_rail_b,
  input  logic loss_mask,
  input  logic loss_clr,
  output logic line_pos,
  output logic line_neg,
  output logic loss_status,
  output logic loss_irq
);

  logic smp_a, smp_b;

  tlc_sampler u_sampler (
    .clk      (tclk),
    .rst_n    (rst_n),
    .fall_sel (cfg_fall_edge),
    .invert   (cfg_invert),
    .rail_a   (sys_rail_a),
    .rail_b   (sys_rail_b),
    .smp_a    (smp_a),
    .smp_b    (smp_b)
  );

  tlc_coder u_coder (
    .clk       (tclk),
    .rst_n     (rst_n),
    .cfg_t1    (cfg_t1),
    .cfg_dual  (cfg_dual),
    .cfg_subst (cfg_subst),
    .smp_a     (smp_a),
    .smp_b     (smp_b),
    .line_pos  (line_pos),
    .line_neg  (line_neg)
  );

  tlc_clk_monitor #(.LOSS_LIMIT(LOSS_LIMIT)) u_monitor (
    .mclk   (mclk),
    .rst_n  (rst_n),
    .tclk   (tclk),
    .mask   (loss_mask),
    .clr    (loss_clr),
    .status (loss_status),
    .irq    (loss_irq)
  );

endmodule

// File: tb/tx_line_coder_tb_top.sv
module tx_line_coder_tb_top;

  logic mclk = 1'b0;
  logic tclk = 1'b0;
  logic rst_n = 1'b0;
  bit   tclk_en = 1'b1;
  logic cfg_t1 = 1'b0, cfg_dual = 1'b0, cfg_subst = 1'b0, cfg_fall = 1'b0, cfg_inv = 1'b0;
  logic rail_a = 1'b0, rail_b = 1'b0, loss_mask = 1'b0, loss_clr = 1'b0;
  logic line_pos, line_neg, loss_status, loss_irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  int q_t[$];
  int q_s[$];
  int q_r[$];
  int exp_sym[$];

  tx_line_coder dut_i (
    .tclk(tclk), .mclk(mclk), .rst_n(rst_n),
    .cfg_t1(cfg_t1), .cfg_dual(cfg_dual), .cfg_subst(cfg_subst),
    .cfg_fall_edge(cfg_fall), .cfg_invert(cfg_inv),
    .sys_rail_a(rail_a), .sys_rail_b(rail_b),
    .loss_mask(loss_mask), .loss_clr(loss_clr),
    .line_pos(line_pos), .line_neg(line_neg),
    .loss_status(loss_status), .loss_irq(loss_irq)
  );

  always #5 mclk = ~mclk;                       // 100 MHz master clock
  always begin #20; if (tclk_en || tclk) tclk = ~tclk; end
  always @(posedge tclk) cyc <= cyc + 1;

  task automatic check(input bit ok, input int req, input int act, input int expv, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // scoreboard monitor: compares line symbols against queued expectations
  always @(negedge tclk) begin
    int sym;
    sym = line_pos ? 1 : (line_neg ? -1 : 0);
    if (line_pos && line_neg) check(1'b0, 12, 3, 0, "both rails high");   // R12
    while (q_t.size() > 0 && q_t[0] < cyc) begin
      check(1'b0, q_r[0], q_t[0], cyc, "symbol slot missed");
      void'(q_t.pop_front()); void'(q_s.pop_front()); void'(q_r.pop_front());
    end
    if (q_t.size() > 0 && q_t[0] == cyc) begin
      check(sym == q_s[0], q_r[0], sym, q_s[0], "line symbol");
      void'(q_t.pop_front()); void'(q_s.pop_front()); void'(q_r.pop_front());
    end
  end

  function automatic bit zeros_at(input string p, input int i, input int k);
    for (int j = 0; j < k; j++) begin
      if (i + j >= p.len()) return 1'b0;
      if (p[i+j] != "0") return 1'b0;
    end
    return 1'b1;
  endfunction

  // reference coder for single rail (R3, R4, R5): polarities written out directly
  task automatic build_single(input string pat, input bit t1, input bit subst);
    int last;
    int par;
    int i;
    last = -1; par = 0; i = 0;
    exp_sym.delete();
    while (i < pat.len()) begin
      if (subst && t1 && zeros_at(pat, i, 8)) begin           // R4
        exp_sym.push_back(0); exp_sym.push_back(0); exp_sym.push_back(0);
        exp_sym.push_back(last); exp_sym.push_back(-last); exp_sym.push_back(0);
        exp_sym.push_back(-last); exp_sym.push_back(last);
        i += 8;
      end else if (subst && !t1 && zeros_at(pat, i, 4)) begin // R5
        if (par == 0) begin last = -last; exp_sym.push_back(last); end
        else exp_sym.push_back(0);
        exp_sym.push_back(0); exp_sym.push_back(0); exp_sym.push_back(last);
        par = 0;
        i += 4;
      end else if (pat[i] == "1") begin
        last = -last; exp_sym.push_back(last); par ^= 1; i++;
      end else begin
        exp_sym.push_back(0); i++;
      end
    end
  endtask

  task automatic apply_cfg(input bit t1, input bit dual, input bit subst, input bit fall, input bit inv);
    rst_n = 1'b0;
    cfg_t1 = t1; cfg_dual = dual; cfg_subst = subst; cfg_fall = fall; cfg_inv = inv;
    repeat (2) @(posedge tclk);
  endtask

  task automatic drain(input int req);
    repeat (13) @(posedge tclk);
    @(negedge tclk);
    check(q_t.size() == 0, req, q_t.size(), 0, "expectations left over");
    check(!(line_pos && line_neg), 12, int'(line_pos) + int'(line_neg), 1, "rails exclusive"); // R12
  endtask

  // driver: each bit is driven after a rising edge; expectation pushed with its arrival cycle (R6, R8)
  task automatic run_single(input string pat, input bit t1, input bit subst, input bit fall,
                            input bit inv, input int req);
    int lat;
    lat = fall ? 9 : 10;
    build_single(pat, t1, subst);
    apply_cfg(t1, 1'b0, subst, fall, inv);
    for (int i = 0; i < pat.len(); i++) begin
      @(posedge tclk); #2;
      if (i == 0) rst_n = 1'b1;
      rail_a = (pat[i] == "1") ^ inv;
      rail_b = inv;
      q_t.push_back(cyc + lat); q_s.push_back(exp_sym[i]); q_r.push_back(req);
    end
    drain(req);
  endtask

  task automatic run_dual(input string pa, input string pb, input bit t1, input bit fall,
                          input bit inv, input int req);
    int lat;
    bit a;
    bit b;
    lat = fall ? 9 : 10;
    apply_cfg(t1, 1'b1, 1'b1, fall, inv);
    for (int i = 0; i < pa.len(); i++) begin
      a = (pa[i] == "1");
      b = (pb[i] == "1");
      @(posedge tclk); #2;
      if (i == 0) rst_n = 1'b1;
      rail_a = a ^ inv;
      rail_b = b ^ inv;
      q_t.push_back(cyc + lat);
      q_s.push_back((a && !b) ? -1 : ((!a && b) ? 1 : 0));
      q_r.push_back(req);
    end
    drain(req);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    apply_cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(posedge tclk);
    @(negedge tclk);
    check(!line_pos && !line_neg, 1, int'(line_pos) + int'(line_neg), 0, "rails during reset");
    check(!loss_status, 1, int'(loss_status), 0, "loss status during reset");
    check(!loss_irq, 1, int'(loss_irq), 0, "irq during reset");

    // R3, R6: plain alternation on T1, rising-edge sampling
    run_single("1101001110001011", 1'b1, 1'b0, 1'b0, 1'b0, 3);
    // R3, R8: plain alternation on E1, falling-edge sampling, long zeros stay spaces
    run_single("1011100000000000011011", 1'b0, 1'b0, 1'b1, 1'b0, 8);
    // R4: eight-zero substitution with runs of 8, 16, 7 and 9 zeros
    run_single("1000000001100000000000000001000000010000000001011", 1'b1, 1'b1, 1'b0, 1'b0, 4);
    // R4, R8: B8ZS with a negative pulse before the run, falling edge
    run_single("11000000001000000001", 1'b1, 1'b1, 1'b1, 1'b0, 4);
    // R5: four-zero substitution after odd and even pulse counts, back-to-back runs
    run_single("10000110000000010001000001110000101", 1'b0, 1'b1, 1'b0, 1'b0, 5);
    // R7: inversion with HDB3 on falling edge
    run_single("1010000110000101", 1'b0, 1'b1, 1'b1, 1'b1, 7);
    // R7: inversion with plain alternation on T1
    run_single("1100100011", 1'b1, 1'b0, 1'b0, 1'b1, 7);
    // R2: dual rail on T1 with substitution requested but bypassed
    run_dual("101101000000000001", "011010000000000001", 1'b1, 1'b0, 1'b0, 2);
    // R2, R7: dual rail on E1, inverted inputs, falling edge
    run_dual("1100100000110", "0101010000010", 1'b0, 1'b1, 1'b1, 2);

    // R9..R11: transmit clock loss
    apply_cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (200) @(posedge mclk); #1;
    check(!loss_status, 9, int'(loss_status), 0, "no loss while clock runs");
    tclk_en = 1'b0;
    repeat (60) @(posedge mclk); #1;
    check(!loss_status, 9, int'(loss_status), 0, "below the idle limit");
    repeat (40) @(posedge mclk); #1;
    check(loss_status, 9, int'(loss_status), 1, "beyond the idle limit");
    check(loss_irq, 11, int'(loss_irq), 1, "irq unmasked");
    loss_mask = 1'b1; #1;
    check(!loss_irq, 11, int'(loss_irq), 0, "irq masked");
    check(loss_status, 11, int'(loss_status), 1, "status unaffected by mask");
    loss_mask = 1'b0;
    tclk_en = 1'b1;
    repeat (100) @(posedge mclk); #1;
    check(loss_status, 10, int'(loss_status), 1, "sticky after clock returns");
    @(posedge mclk); #1 loss_clr = 1'b1;
    @(posedge mclk); #1 loss_clr = 1'b0;
    check(!loss_status, 10, int'(loss_status), 0, "cleared by write-one");
    check(!loss_irq, 11, int'(loss_irq), 0, "irq follows clear");
    repeat (50) @(posedge mclk); #1;
    check(!loss_status, 10, int'(loss_status), 0, "stays clear with clock present");

    finish_run();
  end

endmodule